// File: doc/BRIEF.md
# Converter Serial Readout Controller (master clock mode)

This block drives the digital output of a sampling converter whose host reads results over a three-wire serial link that the block clocks itself. A rising edge on the start input begins a conversion. The conversion is modelled as a timer with a fixed length. When the timer expires, the block samples the result word presented on its data input. It then sends the word MSB first on a data line, together with a serial clock it generates and a frame strobe that marks the valid bits.

There are two readout orders. In late readout, the result of a conversion is sent as soon as that conversion finishes, and the busy flag stays high until the final bit has gone out. In overlapped readout, the result of the previous conversion is sent while the next conversion runs, and busy covers only the conversion. The clock polarity and the strobe polarity can each be flipped. A 2-bit divider selects how long a serial clock period lasts, and a select input can switch off the block's own clock so that no frames are sent.

With the default parameters the slowest frame (288 cycles) ends before a conversion (400 cycles) ends, so an overlapped frame always finishes inside its conversion.

Top module: `adc_serial_master`

## Requirements
- R1: While reset is active and directly after it, busy is 0, sclk equals sclk_inv, sync equals sync_inv and sdout is 0.
- R2: A frame carries the 18 result bits MSB first (bit 17 first). Each bit is held for one whole serial clock period and changes only when the non-inverted clock falls, so it is stable across the rising sampling edge.
- R3: The serial clock period is 2, 4, 8 or 16 system cycles for div_sel = 0, 1, 2 or 3. Each period starts with a low half (non-inverted), and div_sel is sampled only on the cycle a frame starts.
- R4: sclk is the non-inverted clock XOR sclk_inv, and sync is high during a frame when sync_inv = 0 and low when sync_inv = 1. A frame lasts exactly 18 clock periods. Outside a frame, sclk sits at sclk_inv and sdout is 0.
- R5: With read_during = 0 at the start, the frame begins on the cycle the conversion ends. It carries the conv_data value sampled at that edge, and busy stays high without a break from the accepted start to the end of the frame: 400 + 18·period cycles.
- R6: With read_during = 1 at the start, busy is high for exactly 400 cycles. The frame begins on the same cycle as the conversion and carries the result stored by the last overlapped conversion. If no result is stored, no frame is sent.
- R7: A conversion begins only on a 0-to-1 transition of conv_start. A transition that arrives while busy is high is ignored and does not lengthen busy.
- R8: If ext_clk_sel is 1 on the cycle a frame would begin, no frame is sent and busy follows the conversion alone. A stored result that an overlapped start skipped in this way stays stored.
- R9: A late-readout conversion discards any stored result. The next overlapped conversion therefore sends no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| conv_start | input | 1 | Conversion request; its rising edge counts |
| conv_data | input | 18 | Result word, sampled when the conversion timer expires |
| ext_clk_sel | input | 1 | 1 = serial clock supplied from outside; frames are suppressed |
| read_during | input | 1 | 0 = late readout, 1 = overlapped readout of the prior result |
| sclk_inv | input | 1 | Inverts the serial clock and its idle level |
| sync_inv | input | 1 | Inverts the frame strobe |
| div_sel | input | 2 | Serial clock period select: 2 << div_sel cycles |
| busy | output | 1 | Conversion, or late-readout frame, in progress |
| sclk | output | 1 | Serial clock |
| sync | output | 1 | Frame strobe |
| sdout | output | 1 | Serial data |

## Verification
The bench drives both readout orders at each clock period. It goes after several corner cases:
- A late-readout design that let busy fall when the conversion ended would show a gap between the conversion and the frame.
- An overlapped design that replayed a result from a late-readout conversion, or from an overlapped start whose frame was suppressed, would send a frame where none is expected.
- A retrigger is pulsed during busy; a design that accepted it would lengthen busy.
- div_sel is changed in the middle of an overlapped frame; a design that did not hold the period would show bit edges in the wrong cycles.
- The inverted settings are run as well; a wrong idle level would show up as a steady mismatch between frames.

// File: rtl/adc_ser_pkg.sv
package adc_ser_pkg;

    // Readout ordering latched at each accepted start
    typedef enum logic {
        RD_AFTER  = 1'b0,
        RD_DURING = 1'b1
    } rd_mode_e;

endpackage

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int unsigned CONV_CYCLES = 400
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    input  logic busy_i,
    output logic accept_o,
    output logic done_o,
    output logic active_o
);

    localparam int unsigned CNT_W = (CONV_CYCLES > 2) ? $clog2(CONV_CYCLES) : 1;

    typedef struct packed {
        logic             start_q;
        logic             act;
        logic [CNT_W-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.start_q = start_i;
        accept_o    = start_i & ~s_q.start_q & ~busy_i;
        done_o      = s_q.act && (s_q.cnt == '0);
        if (s_q.act) begin
            if (done_o) begin
                s_d.act = 1'b0;
            end else begin
                s_d.cnt = s_q.cnt - 1'b1;
            end
        end
        if (accept_o) begin
            s_d.act = 1'b1;
            s_d.cnt = CNT_W'(CONV_CYCLES - 1);
        end
        active_o = s_q.act;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/adc_frame_shifter.sv
module adc_frame_shifter #(
    parameter int unsigned DATA_W = 18,
    parameter int unsigned DIV_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic [DIV_W-1:0]  div_i,
    output logic              active_o,
    output logic              sclk_o,
    output logic              sdata_o
);

    localparam int unsigned PH_W  = ((1 << DIV_W) - 1 > 0) ? (1 << DIV_W) - 1 : 1;
    localparam int unsigned BIT_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

    typedef struct packed {
        logic              act;
        logic              hi;
        logic [PH_W-1:0]   ph;
        logic [PH_W-1:0]   half;
        logic [BIT_W-1:0]  left;
        logic [DATA_W-1:0] sh;
    } shf_t;

    shf_t s_d, s_q;
    logic [PH_W:0]   span;
    logic [PH_W-1:0] half_m1;

    always_comb begin
        span    = {{PH_W{1'b0}}, 1'b1} << div_i;
        half_m1 = PH_W'(span - 1'b1);
        s_d     = s_q;
        if (s_q.act) begin
            if (s_q.ph == s_q.half) begin
                s_d.ph = '0;
                if (!s_q.hi) begin
                    s_d.hi = 1'b1;
                end else begin
                    s_d.hi = 1'b0;
                    if (s_q.left == '0) begin
                        s_d.act = 1'b0;
                    end else begin
                        s_d.left = s_q.left - 1'b1;
                        s_d.sh   = {s_q.sh[DATA_W-2:0], 1'b0};
                    end
                end
            end else begin
                s_d.ph = s_q.ph + 1'b1;
            end
        end
        if (load_i) begin
            s_d.act  = 1'b1;
            s_d.hi   = 1'b0;
            s_d.ph   = '0;
            s_d.half = half_m1;
            s_d.left = BIT_W'(DATA_W - 1);
            s_d.sh   = data_i;
        end
        active_o = s_q.act;
        sclk_o   = s_q.act & s_q.hi;
        sdata_o  = s_q.act & s_q.sh[DATA_W-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

endmodule

// File: rtl/adc_serial_master.sv
module adc_serial_master
    import adc_ser_pkg::*;
#(
    parameter int unsigned DATA_W      = 18,
    parameter int unsigned CONV_CYCLES = 400,
    parameter int unsigned DIV_W       = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              conv_start,
    input  logic [DATA_W-1:0] conv_data,
    input  logic              ext_clk_sel,
    input  logic              read_during,
    input  logic              sclk_inv,
    input  logic              sync_inv,
    input  logic [DIV_W-1:0]  div_sel,
    output logic              busy,
    output logic              sclk,
    output logic              sync,
    output logic              sdout
);

    typedef struct packed {
        rd_mode_e          mode;
        logic              pvld;
        logic [DATA_W-1:0] pend;
    } top_t;

    top_t s_d, s_q;

    logic              accept, done, conv_act;
    logic              sh_act, sclk_raw, sd_raw;
    logic              busy_w, load_after, load_during, load;
    logic [DATA_W-1:0] load_data;

    assign busy_w = conv_act | sh_act;

    adc_conv_timer #(
        .CONV_CYCLES(CONV_CYCLES)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (conv_start),
        .busy_i  (busy_w),
        .accept_o(accept),
        .done_o  (done),
        .active_o(conv_act)
    );

    adc_frame_shifter #(
        .DATA_W(DATA_W),
        .DIV_W (DIV_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load),
        .data_i  (load_data),
        .div_i   (div_sel),
        .active_o(sh_act),
        .sclk_o  (sclk_raw),
        .sdata_o (sd_raw)
    );

    always_comb begin
        s_d         = s_q;
        load_after  = done & (s_q.mode == RD_AFTER) & ~ext_clk_sel;
        load_during = accept & read_during & s_q.pvld & ~ext_clk_sel;
        load        = load_after | load_during;
        load_data   = load_after ? conv_data : s_q.pend;
        if (accept) begin
            s_d.mode = rd_mode_e'(read_during);
        end
        if (load_during) begin
            s_d.pvld = 1'b0;
        end
        if (done) begin
            if (s_q.mode == RD_DURING) begin
                s_d.pend = conv_data;
                s_d.pvld = 1'b1;
            end else begin
                s_d.pvld = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy  = busy_w;
    assign sclk  = sclk_raw ^ sclk_inv;
    assign sync  = sh_act ^ sync_inv;
    assign sdout = sd_raw;

endmodule

// File: rtl/adc_serial_master_chk.sv
module adc_serial_master_chk (
    input logic clk,
    input logic rst_n,
    input logic conv_start,
    input logic sclk_inv,
    input logic sync_inv,
    input logic busy,
    input logic sclk,
    input logic sync,
    input logic sdout
);

    logic frame_on, sclk_plain;
    assign frame_on   = sync ^ sync_inv;
    assign sclk_plain = sclk ^ sclk_inv;

    // R4: idle levels between frames
    a_r4_idle_levels: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_on |-> (sclk == sclk_inv && sdout == 1'b0));

    // R5: a frame never runs outside busy at default timing
    a_r5_frame_under_busy: assert property (@(posedge clk) disable iff (!rst_n)
        frame_on |-> busy);

    // R2: data held while the plain clock is high
    a_r2_data_held: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_on && $past(frame_on) && sclk_plain && $stable(sclk_inv)) |-> $stable(sdout));

    // R7: busy only rises after a start request was seen high
    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(conv_start));

endmodule

bind adc_serial_master adc_serial_master_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .conv_start(conv_start),
    .sclk_inv  (sclk_inv),
    .sync_inv  (sync_inv),
    .busy      (busy),
    .sclk      (sclk),
    .sync      (sync),
    .sdout     (sdout)
);

// File: tb/adc_serial_master_bench.sv
module adc_serial_master_bench;

    localparam int CLK_P = 10;
    localparam int CONV  = 400;
    localparam int NBIT  = 18;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        conv_start = 1'b0;
    logic [17:0] conv_data = '0;
    logic        ext_clk_sel = 1'b0;
    logic        read_during = 1'b0;
    logic        sclk_inv = 1'b0;
    logic        sync_inv = 1'b0;
    logic [1:0]  div_sel = '0;
    logic        busy, sclk, sync, sdout;

    int total = 0;
    int bad   = 0;
    int nb    = 0;
    int ns    = 0;

    always #(CLK_P/2) clk = ~clk;

    adc_serial_master u_adc_serial_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .conv_start (conv_start),
        .conv_data  (conv_data),
        .ext_clk_sel(ext_clk_sel),
        .read_during(read_during),
        .sclk_inv   (sclk_inv),
        .sync_inv   (sync_inv),
        .div_sel    (div_sel),
        .busy       (busy),
        .sclk       (sclk),
        .sync       (sync),
        .sdout      (sdout)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference: event times kept as integers
    int          cyc = 0;
    bit          m_conv = 0, m_mode = 0, m_pv = 0, m_fr = 0, m_prev = 0;
    int          m_cend = 0, m_fs = 0, m_fp = 2;
    logic [17:0] m_pd = '0, m_fd = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_conv = 0; m_mode = 0; m_pv = 0; m_fr = 0; m_prev = 0;
        end else begin
            bit was_busy;
            cyc++;
            was_busy = m_conv | m_fr;
            if (m_fr && cyc == m_fs + NBIT * m_fp) m_fr = 0;
            if (m_conv && cyc == m_cend) begin
                m_conv = 0;
                if (!m_mode) begin
                    if (!ext_clk_sel) begin
                        m_fr = 1; m_fs = cyc; m_fd = conv_data; m_fp = 2 << div_sel;
                    end
                    m_pv = 0;
                end else begin
                    m_pd = conv_data; m_pv = 1;
                end
            end
            if (conv_start && !m_prev && !was_busy) begin
                m_conv = 1; m_cend = cyc + CONV; m_mode = read_during;
                if (read_during && m_pv && !ext_clk_sel) begin
                    m_fr = 1; m_fs = cyc; m_fd = m_pd; m_fp = 2 << div_sel; m_pv = 0;
                end
            end
            m_prev = conv_start;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            int  o;
            bit  e_sclk, e_sd;
            o      = cyc - m_fs;
            e_sclk = (m_fr && (o % m_fp) >= m_fp / 2) ^ sclk_inv;
            e_sd   = m_fr ? m_fd[NBIT - 1 - o / m_fp] : 1'b0;
            chk(busy == (m_conv | m_fr), "R5", "busy", busy, m_conv | m_fr);
            chk(sync == (m_fr ^ sync_inv), "R4", "sync", sync, m_fr ^ sync_inv);
            chk(sclk == e_sclk, "R3", "sclk", sclk, e_sclk);
            chk(sdout == e_sd, "R2", "sdout", sdout, e_sd);
            if (busy) nb++;
            if (sync != sync_inv) ns++;
        end
    end

    task automatic run_conv(input bit rd, input bit ext, input logic [1:0] dv,
                            input logic [17:0] dat, input int exp_busy,
                            input int exp_sync, input string tag);
        @(posedge clk); #1;
        read_during = rd; ext_clk_sel = ext; div_sel = dv; conv_data = dat;
        nb = 0; ns = 0; conv_start = 1'b1;
        repeat (3) @(posedge clk);
        #1 conv_start = 1'b0;
        repeat (6) @(posedge clk);
        #1 conv_start = 1'b1;                 // R7: retrigger while busy
        if (rd) div_sel = ~dv;                // R3: change inside overlapped frame
        repeat (2) @(posedge clk);
        #1 conv_start = 1'b0;
        @(negedge clk);
        while (busy) @(negedge clk);
        repeat (3) @(posedge clk);
        #1;
        chk(nb == exp_busy, tag, "busy cycles", nb, exp_busy);
        chk(ns == exp_sync, tag, "frame cycles", ns, exp_sync);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL R5 watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
        chk(sync == 1'b0, "R1", "sync in reset", sync, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b0 && sdout == 1'b0, "R1", "sclk/sdout after reset", {sclk, sdout}, 0);
        // R5: late readout, fastest clock
        run_conv(1'b0, 1'b0, 2'd0, 18'h2A5C3, CONV + NBIT * 2, NBIT * 2, "R5/R7");
        // R4: inverted polarities, slowest clock
        @(posedge clk); #1 sclk_inv = 1'b1; sync_inv = 1'b1;
        @(negedge clk);
        chk(sclk == 1'b1 && sync == 1'b1, "R4", "inverted idle", {sclk, sync}, 3);
        run_conv(1'b0, 1'b0, 2'd3, 18'h1F00E, CONV + NBIT * 16, NBIT * 16, "R4");
        // R9: nothing stored after late readout
        run_conv(1'b1, 1'b0, 2'd1, 18'h0BEEF, CONV, 0, "R9");
        // R6: overlapped frame of previous result, period 8
        run_conv(1'b1, 1'b0, 2'd2, 18'h35A5A, CONV, NBIT * 8, "R6/R3");
        @(posedge clk); #1 sclk_inv = 1'b0; sync_inv = 1'b0;
        // R8: external clock select suppresses late frame
        run_conv(1'b0, 1'b1, 2'd0, 18'h12345, CONV, 0, "R8");
        run_conv(1'b1, 1'b0, 2'd1, 18'h3C3C3, CONV, 0, "R8");
        run_conv(1'b1, 1'b1, 2'd1, 18'h2D2D2, CONV, 0, "R8");
        // R6: stored result still sent after a suppressed overlapped start
        run_conv(1'b1, 1'b0, 2'd1, 18'h00001, CONV, NBIT * 4, "R6");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule